// File: doc/BRIEF.md
# Fuse seed programming sequencer

This block provisions a 512-bit secret seed into one-time-programmable fuses without any software in the loop. After reset it waits for a programming request. When the request arrives it raises a busy flag and pulls sixteen 32-bit words from an entropy source through a valid/ready word port. It then drives a single-outstanding register-bus master into the direct-access interface of a fuse controller. For each step it polls the controller status until idle, loads one or two data words, loads the fuse address, issues a write command and polls again. After the last step it requests a partition digest over the same base address.

The fuse access width is 32 or 64 bits, taken from bit 6 of a hardware configuration word. The address stride and the number of data registers loaded per step follow that width. Every status poll is bounded by a programmable limit. An error reported by the controller ends the flow early. The block finishes by setting exactly one of a pass flag or a fail flag, and only then drops busy. The flow runs at most once per reset.

Top module: `fuse_seed_prog`

## Requirements
- R1: After reset, and until the program request input is seen high, busy, pass and fail stay low, no bus request is raised and the entropy port is not ready. Once the flow has ended, the request input is ignored until the next reset.
- R2: On a request the block raises busy and accepts exactly 16 entropy words (valid and ready both high at a clock edge) before it makes any bus access. Seed word i, in order of arrival, belongs to fuse word i.
- R3: Bit 6 of the configuration word, sampled at the request, selects the access width: 0 gives 32-bit steps, 1 gives 64-bit steps. No other bit of that word has any effect.
- R4: Before loading data for each step, the block reads the status register at controller base + 0x10. It continues only after a read shows bit 0 (idle) set with bit 1 (error) clear.
- R5: In 32-bit mode each step writes one seed word to offset 0x44 and never touches 0x48. In 64-bit mode each step writes seed word 2k to 0x44 and word 2k+1 to 0x48.
- R6: Each step writes the fuse address to offset 0x40 and then the value 0x2 to offset 0x3C. The first address is the low 32 bits of the programming base. Each later address is the previous one plus 4 (32-bit mode) or plus 8 (64-bit mode).
- R7: After each command the block polls status until idle before any further register write. The write sequence ends after 16 or 8 steps.
- R8: After the last step the block writes the programming base low word to 0x40, then 0x4 to 0x3C, then polls until idle. This happens once, and then pass is set.
- R9: A status read with bit 1 set, in any poll, ends the flow with fail set. No further command is issued, so a write error skips the digest.
- R10: A poll that sees a given number of consecutive busy reads (the poll limit input) gives up after that read and ends the flow with fail set.
- R11: Pass and fail are never high together. Exactly one of them is set by the clock edge at which busy falls. Both hold until reset.
- R12: The bus carries one transaction at a time. The request stays high, with address, write enable and write data unchanged, until acknowledged. The bus address is the 64-bit controller base plus the register offset, with full carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_req_i | input | 1 | Programming request |
| hw_cfg_i | input | 32 | Hardware configuration word; bit 6 selects 64-bit access |
| prog_base_i | input | 64 | Fuse programming base address; low 32 bits used |
| fc_base_i | input | 64 | Fuse controller register base address |
| poll_limit_i | input | 16 | Busy status reads allowed per poll loop |
| ent_valid_i | input | 1 | Entropy word valid |
| ent_data_i | input | 32 | Entropy word |
| ent_ready_o | output | 1 | Entropy word accepted when high with valid |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | 64 | Bus address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ack_i | input | 1 | Bus acknowledge, one cycle |
| bus_rdata_i | input | 32 | Bus read data, valid with acknowledge |
| busy_o | output | 1 | Programming in progress |
| pass_o | output | 1 | Flow finished successfully |
| fail_o | output | 1 | Flow finished with error or timeout |

## Verification
The assertions assume the bus target acknowledges only while a request is pending, with a single-cycle acknowledge. They also assume that the controller base, programming base and configuration inputs hold steady while busy is high. The bench's register model acknowledges one request at a time after a chosen latency, at the falling edge, and drops acknowledge on the following falling edge. Configuration inputs are changed only while reset is held. The entropy model withdraws valid on some cycles, so the handshake is exercised under gaps.

// File: rtl/fsp_pkg.sv
// Package: shared constants and state type of the fuse seed sequencer.
// Assumes a 12-bit register offset space in the fuse controller.
package fsp_pkg;
    localparam int OFF_W = 12;
    localparam logic [OFF_W-1:0] OFF_STATUS = 12'h010;
    localparam logic [OFF_W-1:0] OFF_CMD    = 12'h03C;
    localparam logic [OFF_W-1:0] OFF_ADDR   = 12'h040;
    localparam logic [OFF_W-1:0] OFF_WD0    = 12'h044;
    localparam logic [OFF_W-1:0] OFF_WD1    = 12'h048;
    localparam logic [31:0] OP_WRITE  = 32'h2;
    localparam logic [31:0] OP_DIGEST = 32'h4;
    localparam int STAT_IDLE_BIT = 0;
    localparam int STAT_ERR_BIT  = 1;
    localparam int WIDE_SEL_BIT  = 6;

    typedef enum logic [3:0] {
        S_IDLE, S_COLLECT, S_PRE_POLL, S_WD0, S_WD1, S_ADDR, S_CMD,
        S_POST_POLL, S_DADDR, S_DCMD, S_DPOLL, S_REPORT, S_DONE
    } seq_state_e;
endpackage

// File: rtl/fsp_seed_buf.sv
// Seed buffer: gathers NWORDS entropy words in arrival order while collect_i
// is high and offers two adjacent words for reading.
// Assumes collect_i is held until full_o and that NWORDS is a power of two.
module fsp_seed_buf #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              collect_i,
    input  logic              ent_valid_i,
    input  logic [WORD_W-1:0] ent_data_i,
    output logic              ent_ready_o,
    output logic              full_o,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] rd_word0_o,
    output logic [WORD_W-1:0] rd_word1_o
);
    localparam int SEL_W = $clog2(NWORDS);

    logic [IDX_W-1:0]  fill_q;
    logic [WORD_W-1:0] words_q [NWORDS];
    logic              take;
    logic [SEL_W-1:0]  sel0;
    logic [SEL_W-1:0]  sel1;

    assign ent_ready_o = collect_i && (fill_q < IDX_W'(NWORDS));
    assign full_o      = (fill_q == IDX_W'(NWORDS));
    assign take        = ent_valid_i && ent_ready_o;

    // Count accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n)    fill_q <= '0;
        else if (take) fill_q <= fill_q + IDX_W'(1);
    end

    // One storage register per seed word, written when its slot is next.
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                                words_q[g] <= '0;
            else if (take && fill_q == IDX_W'(g))      words_q[g] <= ent_data_i;
        end
    end

    assign sel0       = rd_idx_i[SEL_W-1:0];
    assign sel1       = sel0 + SEL_W'(1);
    assign rd_word0_o = words_q[sel0];
    assign rd_word1_o = words_q[sel1];
endmodule

// File: rtl/fsp_bus_master.sv
// Bus master: launches one register transaction per command, holds it until
// acknowledged and reports completion in the acknowledge cycle.
// Assumes the target acknowledges for exactly one cycle per request.
module fsp_bus_master #(
    parameter int ADDR_W = 64,
    parameter int WORD_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              cmd_valid_i,
    input  logic              cmd_we_i,
    input  logic [OFF_W-1:0]  cmd_off_i,
    input  logic [WORD_W-1:0] cmd_wdata_i,
    output logic              done_o,
    output logic [WORD_W-1:0] rdata_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [WORD_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [WORD_W-1:0] bus_rdata_i
);
    // Launch a transaction when idle, retire it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req_o   <= 1'b0;
            bus_we_o    <= 1'b0;
            bus_addr_o  <= '0;
            bus_wdata_o <= '0;
        end else if (bus_req_o && bus_ack_i) begin
            bus_req_o <= 1'b0;
        end else if (!bus_req_o && cmd_valid_i) begin
            bus_req_o   <= 1'b1;
            bus_we_o    <= cmd_we_i;
            bus_addr_o  <= base_i + ADDR_W'(cmd_off_i);
            bus_wdata_o <= cmd_wdata_i;
        end
    end

    assign done_o  = bus_req_o && bus_ack_i;
    assign rdata_o = bus_rdata_i;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o))); // R12
endmodule

// File: rtl/fsp_poll_timer.sv
// Poll timer: counts consecutive busy status reads of one poll loop and flags
// the read that reaches the limit.
// Assumes the sequencer bumps only when last_o is low and clears on loop exit.
module fsp_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             bump_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             last_o
);
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + (TMO_W+1)'(1);
    assign last_o   = cnt_next >= {1'b0, limit_i};

    // Busy-read counter, restarted at every loop exit.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (bump_i)  cnt_q <= cnt_next[TMO_W-1:0];
    end

    AST_NO_BUMP_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bump_i |-> !last_o); // R10
endmodule

// File: rtl/fuse_seed_prog.sv
// Fuse seed programming sequencer (top): collects a seed from an entropy port,
// writes it through the fuse controller direct-access registers step by step,
// requests a partition digest and reports pass or fail.
// Assumes configuration inputs hold steady while busy_o is high and that
// NWORDS is even when 64-bit access is selected.
module fuse_seed_prog
    import fsp_pkg::*;
#(
    parameter int SEED_BITS = 512,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 64,
    parameter int TMO_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req_i,
    input  logic [31:0]       hw_cfg_i,
    input  logic [ADDR_W-1:0] prog_base_i,
    input  logic [ADDR_W-1:0] fc_base_i,
    input  logic [TMO_W-1:0]  poll_limit_i,
    input  logic              ent_valid_i,
    input  logic [WORD_W-1:0] ent_data_i,
    output logic              ent_ready_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [WORD_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [WORD_W-1:0] bus_rdata_i,
    output logic              busy_o,
    output logic              pass_o,
    output logic              fail_o
);
    localparam int NWORDS     = SEED_BITS / WORD_W;
    localparam int IDX_W      = $clog2(NWORDS + 1);
    localparam int WORD_BYTES = WORD_W / 8;

    seq_state_e        state_q;
    logic [IDX_W-1:0]  word_idx_q;
    logic [WORD_W-1:0] fuse_addr_q;
    logic              wide_q;
    logic              busy_q, pass_q, fail_q;

    logic              full;
    logic [WORD_W-1:0] word0, word1;
    logic              cmd_valid, cmd_we;
    logic [OFF_W-1:0]  cmd_off;
    logic [WORD_W-1:0] cmd_wdata;
    logic              done;
    logic [WORD_W-1:0] rdata;
    logic              in_poll, st_idle, st_err, poll_last;
    logic              tmr_clear, tmr_bump;
    logic [IDX_W-1:0]  step;
    logic [WORD_W-1:0] stride;
    logic              last_step;

    fsp_seed_buf #(.WORD_W(WORD_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_seed (
        .clk(clk), .rst_n(rst_n), .collect_i(state_q == S_COLLECT),
        .ent_valid_i(ent_valid_i), .ent_data_i(ent_data_i),
        .ent_ready_o(ent_ready_o), .full_o(full),
        .rd_idx_i(word_idx_q), .rd_word0_o(word0), .rd_word1_o(word1)
    );

    fsp_bus_master #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .base_i(fc_base_i),
        .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we), .cmd_off_i(cmd_off),
        .cmd_wdata_i(cmd_wdata), .done_o(done), .rdata_o(rdata),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i)
    );

    fsp_poll_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear_i(tmr_clear), .bump_i(tmr_bump),
        .limit_i(poll_limit_i), .last_o(poll_last)
    );

    assign in_poll   = (state_q == S_PRE_POLL) || (state_q == S_POST_POLL) || (state_q == S_DPOLL);
    assign st_idle   = rdata[STAT_IDLE_BIT];
    assign st_err    = rdata[STAT_ERR_BIT];
    assign tmr_bump  = in_poll && done && !st_err && !st_idle && !poll_last;
    assign tmr_clear = !in_poll || (done && (st_err || st_idle));
    assign step      = wide_q ? IDX_W'(2) : IDX_W'(1);
    assign stride    = wide_q ? WORD_W'(2 * WORD_BYTES) : WORD_W'(WORD_BYTES);
    assign last_step = ({1'b0, word_idx_q} + {1'b0, step}) >= (IDX_W+1)'(NWORDS);

    // Select the register access that the current state needs.
    always_comb begin
        cmd_valid = 1'b1;
        cmd_we    = 1'b1;
        cmd_off   = OFF_STATUS;
        cmd_wdata = '0;
        unique case (state_q)
            S_PRE_POLL, S_POST_POLL, S_DPOLL: cmd_we = 1'b0;
            S_WD0:   begin cmd_off = OFF_WD0;  cmd_wdata = word0; end
            S_WD1:   begin cmd_off = OFF_WD1;  cmd_wdata = word1; end
            S_ADDR:  begin cmd_off = OFF_ADDR; cmd_wdata = fuse_addr_q; end
            S_CMD:   begin cmd_off = OFF_CMD;  cmd_wdata = WORD_W'(OP_WRITE); end
            S_DADDR: begin cmd_off = OFF_ADDR; cmd_wdata = prog_base_i[WORD_W-1:0]; end
            S_DCMD:  begin cmd_off = OFF_CMD;  cmd_wdata = WORD_W'(OP_DIGEST); end
            default: cmd_valid = 1'b0;
        endcase
    end

    // Main sequence: collect, per-step write loop, digest, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            word_idx_q  <= '0;
            fuse_addr_q <= '0;
            wide_q      <= 1'b0;
            busy_q      <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (prog_req_i) begin
                    state_q <= S_COLLECT;
                    busy_q  <= 1'b1;
                    wide_q  <= hw_cfg_i[WIDE_SEL_BIT];
                end
                S_COLLECT: if (full) begin
                    state_q     <= S_PRE_POLL;
                    word_idx_q  <= '0;
                    fuse_addr_q <= prog_base_i[WORD_W-1:0];
                end
                S_PRE_POLL: if (done) begin
                    if (st_err || (!st_idle && poll_last)) begin
                        fail_q <= 1'b1; state_q <= S_REPORT;
                    end else if (st_idle) begin
                        state_q <= S_WD0;
                    end
                end
                S_WD0:  if (done) state_q <= wide_q ? S_WD1 : S_ADDR;
                S_WD1:  if (done) state_q <= S_ADDR;
                S_ADDR: if (done) state_q <= S_CMD;
                S_CMD:  if (done) state_q <= S_POST_POLL;
                S_POST_POLL: if (done) begin
                    if (st_err || (!st_idle && poll_last)) begin
                        fail_q <= 1'b1; state_q <= S_REPORT;
                    end else if (st_idle) begin
                        word_idx_q  <= word_idx_q + step;
                        fuse_addr_q <= fuse_addr_q + stride;
                        state_q     <= last_step ? S_DADDR : S_PRE_POLL;
                    end
                end
                S_DADDR: if (done) state_q <= S_DCMD;
                S_DCMD:  if (done) state_q <= S_DPOLL;
                S_DPOLL: if (done) begin
                    if (st_err || (!st_idle && poll_last)) begin
                        fail_q <= 1'b1; state_q <= S_REPORT;
                    end else if (st_idle) begin
                        pass_q <= 1'b1; state_q <= S_REPORT;
                    end
                end
                S_REPORT: begin
                    busy_q  <= 1'b0;
                    state_q <= S_DONE;
                end
                default: state_q <= S_DONE;
            endcase
        end
    end

    assign busy_o = busy_q;
    assign pass_o = pass_q;
    assign fail_o = fail_q;

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && fail_q)); // R11
    AST_RESULT_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (pass_q ^ fail_q)); // R11
    AST_RESULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_q || fail_q) |=> ($stable(pass_q) && $stable(fail_q))); // R11
    AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !pass_q && !fail_q) |-> (!bus_req_o && !ent_ready_o)); // R1
    AST_NO_BUS_WHILE_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COLLECT) |-> !bus_req_o); // R2
endmodule

// File: tb/tb_fuse_seed_prog.sv
// Directed bench: fuse controller register model and entropy source model,
// one task per scenario, each checking its own results.
module tb_fuse_seed_prog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_req = 1'b0;
    logic [31:0] cfg_hw = '0;
    logic [63:0] cfg_pbase = '0;
    logic [63:0] cfg_fbase = '0;
    logic [15:0] cfg_limit = 16'd8;
    logic        ent_valid = 1'b0;
    logic [31:0] ent_data = '0;
    logic        ent_ready;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [63:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;
    logic        busy, pass, fail;

    int tests = 0, fails = 0;

    // model configuration and observations
    bit          m_wide;
    int          m_lat, m_stall, m_err_at;
    logic [31:0] salt;
    int          lat_cnt, busy_left, cmd_total, wcmd, dcnt, reads, accesses;
    int          bad, early, order_viol, align_bad;
    bit          err_flag, idle_seen, feed_en, hs;
    logic [31:0] wd0, wd1, areg, daddr;
    logic [31:0] fuse [16];
    int          ent_idx, gapc;
    bit          prev_busy;
    int          ord_bad;

    always #5 clk = ~clk;

    fuse_seed_prog dut (
        .clk(clk), .rst_n(rst_n), .prog_req_i(prog_req), .hw_cfg_i(cfg_hw),
        .prog_base_i(cfg_pbase), .fc_base_i(cfg_fbase), .poll_limit_i(cfg_limit),
        .ent_valid_i(ent_valid), .ent_data_i(ent_data), .ent_ready_o(ent_ready),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
        .busy_o(busy), .pass_o(pass), .fail_o(fail)
    );

    function automatic logic [31:0] seed_word(input int i, input logic [31:0] s);
        return 32'hA500_0000 ^ (32'(i) * 32'h0103_0507) ^ s;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Fuse controller register model, acting on the falling edge.
    always @(negedge clk) begin
        logic [63:0] off;
        int idx;
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (lat_cnt < m_lat) lat_cnt++;
            else begin
                lat_cnt = 0;
                bus_ack = 1'b1;
                accesses++;
                if (ent_idx < 16) early++;
                off = bus_addr - cfg_fbase;
                if (bus_we) begin
                    if (off != 64'h10 && !idle_seen) order_viol++;
                    case (off)
                        64'h44: wd0 = bus_wdata;
                        64'h48: begin wd1 = bus_wdata; if (!m_wide) bad++; end
                        64'h40: areg = bus_wdata;
                        64'h3C: begin
                            cmd_total++;
                            if (bus_wdata == 32'h2) begin
                                wcmd++;
                                idx = int'((areg - cfg_pbase[31:0]) >> 2);
                                if (m_wide && areg[2]) align_bad++;
                                if (idx < 0 || idx > (m_wide ? 14 : 15)) bad++;
                                else begin
                                    fuse[idx] = wd0;
                                    if (m_wide) fuse[idx+1] = wd1;
                                end
                            end else if (bus_wdata == 32'h4) begin
                                dcnt++;
                                daddr = areg;
                            end else bad++;
                            if (cmd_total == m_err_at) err_flag = 1'b1;
                            busy_left = m_stall;
                            idle_seen = 1'b0;
                        end
                        default: bad++;
                    endcase
                end else begin
                    if (off != 64'h10) bad++;
                    reads++;
                    bus_rdata = {30'd0, err_flag, busy_left == 0};
                    if (busy_left == 0) idle_seen = 1'b1;
                    else busy_left--;
                end
            end
        end
    end

    // Entropy source model with gaps in valid.
    always @(negedge clk) begin
        if (hs) ent_idx++;
        gapc = (gapc + 1) % 3;
        ent_valid = feed_en && ent_idx < 16 && gapc != 0;
        ent_data = seed_word(ent_idx, salt);
        hs = ent_valid && ent_ready;
    end

    // Ordering monitor: result flag must be present when busy falls.
    always @(negedge clk) begin
        if (rst_n && prev_busy && !busy && !(pass ^ fail)) ord_bad++;
        prev_busy = busy;
    end

    task automatic apply_reset(input bit wide, input int lat, input int stall,
                               input int err_at, input int limit, input logic [31:0] s);
        rst_n = 1'b0;
        prog_req = 1'b0;
        @(posedge clk); #1;
        m_wide = wide; m_lat = lat; m_stall = stall; m_err_at = err_at;
        salt = s;
        cfg_hw = wide ? 32'h0000_0040 : 32'hFFFF_FFBF;
        cfg_pbase = 64'hDEAD_0000_0000_0400;
        cfg_fbase = 64'h0000_0001_FFFF_FFF0;
        cfg_limit = 16'(limit);
        lat_cnt = 0; busy_left = 0; cmd_total = 0; wcmd = 0; dcnt = 0;
        reads = 0; accesses = 0; bad = 0; early = 0; order_viol = 0;
        align_bad = 0; err_flag = 0; idle_seen = 0; feed_en = 1; hs = 0;
        ent_idx = 0; gapc = 0; ord_bad = 0; daddr = '0; areg = '0;
        for (int i = 0; i < 16; i++) fuse[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_end();
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (!busy && (pass || fail)) return;
        end
        chk("R11 flow end", 0, 1);
    endtask

    task automatic test_reset_idle();
        apply_reset(0, 0, 0, 0, 8, 32'h1111_0000);
        repeat (20) @(negedge clk);
        chk("R1 busy idle", busy, 0);
        chk("R1 pass idle", pass, 0);
        chk("R1 fail idle", fail, 0);
        chk("R1 no bus", accesses, 0);
        chk("R1 not ready", ent_ready, 0);
    endtask

    task automatic check_pass(input string tag, input int exp_wcmd, input int exp_reads);
        int mism = 0;
        for (int i = 0; i < 16; i++) if (fuse[i] !== seed_word(i, salt)) mism++;
        chk({tag, " R2 R5 seed words in fuses"}, mism, 0);
        chk({tag, " R2 no early access"}, early, 0);
        chk({tag, " R6 write commands"}, wcmd, exp_wcmd);
        chk({tag, " R8 one digest"}, dcnt, 1);
        chk({tag, " R8 digest address"}, daddr, cfg_pbase[31:0]);
        chk({tag, " R4 status reads"}, reads, exp_reads);
        chk({tag, " R7 no write before idle"}, order_viol, 0);
        chk({tag, " R12 decode"}, bad, 0);
        chk({tag, " R11 pass"}, {pass, fail, busy}, 3'b100);
        chk({tag, " R11 order"}, ord_bad, 0);
    endtask

    task automatic test_narrow_flow();
        apply_reset(0, 0, 0, 0, 8, 32'h0BAD_F00D);
        repeat (5) @(negedge clk);
        chk("R1 waits for request", busy, 0);
        prog_req = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 busy on start", busy, 1);
        wait_end();
        check_pass("R3 narrow", 16, 33);
    endtask

    task automatic test_wide_flow();
        apply_reset(1, 2, 2, 0, 8, 32'h5EED_1234);
        prog_req = 1'b1;
        wait_end();
        check_pass("R3 wide", 8, 35);
        chk("R6 wide stride alignment", align_bad, 0);
    endtask

    task automatic test_once_per_reset();
        int snap;
        apply_reset(0, 1, 0, 0, 8, 32'h0000_7777);
        prog_req = 1'b1;
        wait_end();
        snap = accesses;
        repeat (40) @(negedge clk);
        chk("R1 request ignored after end", accesses, snap);
        chk("R11 flags held", {pass, fail, busy}, 3'b100);
    endtask

    task automatic test_error_write();
        apply_reset(0, 0, 1, 5, 8, 32'h0E0E_0E0E);
        prog_req = 1'b1;
        wait_end();
        chk("R9 stops after error", wcmd, 5);
        chk("R9 digest skipped", dcnt, 0);
        chk("R9 fail", {pass, fail, busy}, 3'b010);
        chk("R11 order on fail", ord_bad, 0);
    endtask

    task automatic test_error_digest();
        apply_reset(0, 0, 0, 17, 8, 32'h0D0D_0D0D);
        prog_req = 1'b1;
        wait_end();
        chk("R9 digest error writes", wcmd, 16);
        chk("R9 digest issued", dcnt, 1);
        chk("R9 digest error fails", {pass, fail}, 2'b01);
    endtask

    task automatic test_timeout();
        apply_reset(1, 0, 1000, 0, 4, 32'h7171_7171);
        prog_req = 1'b1;
        wait_end();
        chk("R10 status reads", reads, 5);
        chk("R10 one command", wcmd, 1);
        chk("R10 no digest", dcnt, 0);
        chk("R10 fail", {pass, fail, busy}, 3'b010);
    endtask

    initial begin
        #(10 * 150000);
        fails++; tests++;
        $display("FAIL watchdog: run did not finish (all requirements)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset_idle();
        test_narrow_flow();
        test_wide_flow();
        test_once_per_reset();
        test_error_write();
        test_error_digest();
        test_timeout();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule